// File: doc/BRIEF.md
# Streaming Spectral Peak Selector

This block sits after the magnitude stage of a spectrum analyser and thins each frame of spectrum samples down to its strongest bins. Every input sample carries an unsigned magnitude and the bin index it came from. While a frame streams in, a chain of 32 compare cells holds the largest magnitudes seen so far, each with its bin index. The cells stay sorted from largest to smallest. A new sample goes into the cell where it fits, and everything below that cell moves down by one. The smallest entry falls off the end of the chain.

When the end-of-frame sample has been taken in, the retained set is copied into an output bank and the chain is emptied for the next frame. The bank is then read out as a short frame ordered by ascending bin index, which lets the host compute each peak's frequency directly. The peak-selection path is used only while the mode input selects it. With the mode input low, every sample passes straight through to the outputs after one register stage.

The mode input must stay constant for the whole of a frame. A frame's peak output finishes 33 cycles after its end-of-frame, so the next end-of-frame must come later than that.

Top module: `spec_peak_picker`

## Requirements
- R1: While reset is high, and in the cycle after it is released, out_valid and out_last are 0.
- R2: In peak mode, a frame's output holds the 32 largest magnitudes of that frame. Magnitudes compare as unsigned numbers.
- R3: Each output entry carries the bin index that arrived with that magnitude.
- R4: Among equal magnitudes, the sample that arrived earlier is kept. With more than 32 equal values, the first 32 arrivals are the ones retained.
- R5: Output entries come out in strictly ascending bin index. out_last is high on the final entry only.
- R6: A frame with N < 32 samples produces exactly N output entries, and a single-sample frame produces one entry with out_last high.
- R7: With peak_en low, each valid sample appears on the outputs one cycle later with its data, index and last flag unchanged. Such samples leave the peak chain untouched, so a later peak-mode frame reports only its own samples.
- R8: The first output entry is valid in the second cycle after the cycle that accepts the end-of-frame sample. The remaining entries follow on consecutive cycles, and out_valid is low in the cycle between.
- R9: The chain is emptied at every end-of-frame, so no entry from one frame appears in the next frame's output.
- R10: Cycles with in_valid low are ignored. Idle gaps inside a frame do not change its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| peak_en | input | 1 | 1 selects peak selection, 0 selects pass-through |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DATA_W | Unsigned magnitude |
| in_idx | input | IDX_W | Bin index of the sample |
| in_last | input | 1 | Marks the final sample of a frame |
| out_valid | output | 1 | Output entry valid |
| out_data | output | DATA_W | Output magnitude |
| out_idx | output | IDX_W | Output bin index |
| out_last | output | 1 | Marks the final entry of an output frame |

## Verification
The hardest case to reach is equal magnitudes competing for the last slots of the chain. With random values this almost never happens. The stimulus therefore sends a frame of 40 identical magnitudes whose bin indices run downward. This makes "arrived first" and "lowest bin" point to different samples: the kept set must be the first 32 arrivals, and the readout must then reverse them into ascending index order. A second directed case sends a frame of large values immediately followed by a frame of small ones. Any entry left behind from the earlier frame would then show up in the output of the later one.

// File: rtl/spec_peak_pkg.sv
package spec_peak_pkg;

  // Source feeding the output register in a given cycle
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_PASS = 2'd1,
    SRC_PEAK = 2'd2
  } out_src_e;

endpackage

// File: rtl/peak_chain.sv
// Sorted insertion chain: cell 0 holds the largest magnitude.
module peak_chain #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 11,
  parameter int NCELLS = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           s_valid,
  input  logic [DATA_W-1:0]              s_data,
  input  logic [IDX_W-1:0]               s_idx,
  input  logic                           s_last,
  output logic                           snap_load,
  output logic [NCELLS-1:0]              snap_val,
  output logic [NCELLS-1:0][DATA_W-1:0]  snap_dat,
  output logic [NCELLS-1:0][IDX_W-1:0]   snap_idx
);

  logic [NCELLS-1:0]             c_val, keep, n_val;
  logic [NCELLS-1:0][DATA_W-1:0] c_dat, n_dat;
  logic [NCELLS-1:0][IDX_W-1:0]  c_idx, n_idx;

  genvar k;
  generate
    for (k = 0; k < NCELLS; k++) begin : g_cell
      // ">=" keeps the held entry on a tie: earlier arrival wins
      assign keep[k] = c_val[k] && (c_dat[k] >= s_data);
      if (k == 0) begin : g_head
        assign n_val[k] = 1'b1;
        assign n_dat[k] = keep[k] ? c_dat[k] : s_data;
        assign n_idx[k] = keep[k] ? c_idx[k] : s_idx;
      end else begin : g_body
        assign n_val[k] = keep[k] | keep[k-1] | c_val[k-1];
        assign n_dat[k] = keep[k] ? c_dat[k] : (keep[k-1] ? s_data : c_dat[k-1]);
        assign n_idx[k] = keep[k] ? c_idx[k] : (keep[k-1] ? s_idx  : c_idx[k-1]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || (s_valid && s_last)) c_val <= '0;
    else if (s_valid)               c_val <= n_val;
  end

  always_ff @(posedge clk) begin
    if (s_valid) begin
      c_dat <= n_dat;
      c_idx <= n_idx;
    end
  end

  // The frame result includes the end-of-frame sample itself
  assign snap_load = s_valid && s_last;
  assign snap_val  = n_val;
  assign snap_dat  = n_dat;
  assign snap_idx  = n_idx;

  generate
    for (k = 0; k < NCELLS - 1; k++) begin : g_chk
      assert_sorted_R2: assert property (@(posedge clk) disable iff (rst)
        c_val[k+1] |-> (c_val[k] && (c_dat[k] >= c_dat[k+1])));
    end
  endgenerate

endmodule

// File: rtl/peak_emit.sv
// Output bank: reads retained entries lowest bin first.
module peak_emit #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 11,
  parameter int NCELLS = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [NCELLS-1:0]              ld_val,
  input  logic [NCELLS-1:0][DATA_W-1:0]  ld_dat,
  input  logic [NCELLS-1:0][IDX_W-1:0]   ld_idx,
  output logic                           fire,
  output logic [DATA_W-1:0]              pick_dat,
  output logic [IDX_W-1:0]               pick_idx,
  output logic                           pick_last
);

  localparam int SEL_W = (NCELLS > 1) ? $clog2(NCELLS) : 1;

  logic [NCELLS-1:0]             pend;
  logic [NCELLS-1:0][DATA_W-1:0] b_dat;
  logic [NCELLS-1:0][IDX_W-1:0]  b_idx;
  logic [SEL_W-1:0]              sel;
  logic                          found;
  logic [IDX_W-1:0]              best;

  // Pick the pending entry with the lowest bin index
  always_comb begin
    found = 1'b0;
    sel   = '0;
    best  = '0;
    for (int k = 0; k < NCELLS; k++) begin
      if (pend[k] && (!found || (b_idx[k] < best))) begin
        found = 1'b1;
        sel   = SEL_W'(k);
        best  = b_idx[k];
      end
    end
  end

  assign fire      = |pend;
  assign pick_dat  = b_dat[sel];
  assign pick_idx  = b_idx[sel];
  assign pick_last = fire && ((pend & (pend - 1'b1)) == '0);

  always_ff @(posedge clk) begin
    if (rst)       pend      <= '0;
    else if (load) pend      <= ld_val;
    else if (fire) pend[sel] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      b_dat <= ld_dat;
      b_idx <= ld_idx;
    end
  end

  assert_ascending_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && $past(fire) && !$past(pick_last) && !$past(load))
      |-> (pick_idx > $past(pick_idx)));

endmodule

// File: rtl/spec_peak_picker.sv
module spec_peak_picker #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 11,
  parameter int NCELLS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              peak_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic              in_last,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [IDX_W-1:0]  out_idx,
  output logic              out_last
);

  import spec_peak_pkg::*;

  logic                          chain_valid;
  logic                          snap_load;
  logic [NCELLS-1:0]             snap_val;
  logic [NCELLS-1:0][DATA_W-1:0] snap_dat;
  logic [NCELLS-1:0][IDX_W-1:0]  snap_idx;
  logic                          fire, pick_last;
  logic [DATA_W-1:0]             pick_dat;
  logic [IDX_W-1:0]              pick_idx;
  out_src_e                      src;

  assign chain_valid = in_valid && peak_en;

  peak_chain #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NCELLS(NCELLS)) u_chain (
    .clk(clk), .rst(rst),
    .s_valid(chain_valid), .s_data(in_data), .s_idx(in_idx), .s_last(in_last),
    .snap_load(snap_load), .snap_val(snap_val), .snap_dat(snap_dat), .snap_idx(snap_idx)
  );

  peak_emit #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NCELLS(NCELLS)) u_emit (
    .clk(clk), .rst(rst),
    .load(snap_load), .ld_val(snap_val), .ld_dat(snap_dat), .ld_idx(snap_idx),
    .fire(fire), .pick_dat(pick_dat), .pick_idx(pick_idx), .pick_last(pick_last)
  );

  always_comb begin
    if (fire)                     src = SRC_PEAK;
    else if (in_valid && !peak_en) src = SRC_PASS;
    else                          src = SRC_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      out_idx   <= '0;
    end else begin
      case (src)
        SRC_PEAK: begin
          out_valid <= 1'b1;
          out_data  <= pick_dat;
          out_idx   <= pick_idx;
          out_last  <= pick_last;
        end
        SRC_PASS: begin
          out_valid <= 1'b1;
          out_data  <= in_data;
          out_idx   <= in_idx;
          out_last  <= in_last;
        end
        default: begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
        end
      endcase
    end
  end

  assert_last_valid_R5: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  assert_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !peak_en && !fire) |=>
      (out_valid && (out_data == $past(in_data)) && (out_idx == $past(in_idx))
       && (out_last == $past(in_last))));

  assert_start_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && peak_en && in_last) |=> ##1 out_valid);

endmodule

// File: tb/spec_peak_picker_tb.sv
`timescale 1ns/1ps
module spec_peak_picker_tb;

  localparam int DW = 16;
  localparam int IW = 11;
  localparam int NC = 32;
  localparam int MAXS = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          peak_en = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [IW-1:0] in_idx = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [IW-1:0] out_idx;
  logic          out_last;

  int n_checks = 0;
  int n_errs   = 0;

  logic [DW-1:0] s_dat [MAXS];
  logic [IW-1:0] s_idx [MAXS];
  int            s_n;
  logic [DW-1:0] e_dat [NC];
  logic [IW-1:0] e_idx [NC];
  int            e_n;

  always #5 clk = ~clk;

  spec_peak_picker #(.DATA_W(DW), .IDX_W(IW), .NCELLS(NC)) u_dut (
    .clk(clk), .rst(rst), .peak_en(peak_en),
    .in_valid(in_valid), .in_data(in_data), .in_idx(in_idx), .in_last(in_last),
    .out_valid(out_valid), .out_data(out_data), .out_idx(out_idx), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference: rank by magnitude (earlier arrival wins ties), keep top NC,
  // then order by ascending bin index.
  task automatic build_expect();
    bit sel [MAXS];
    int last_idx;
    for (int j = 0; j < s_n; j++) begin
      int rank = 0;
      for (int i = 0; i < s_n; i++)
        if ((s_dat[i] > s_dat[j]) || ((s_dat[i] == s_dat[j]) && (i < j))) rank++;
      sel[j] = (rank < NC);
    end
    e_n = 0;
    last_idx = -1;
    for (int r = 0; r < NC; r++) begin
      int best = -1;
      for (int j = 0; j < s_n; j++)
        if (sel[j] && (int'(s_idx[j]) > last_idx) &&
            ((best < 0) || (s_idx[j] < s_idx[best]))) best = j;
      if (best >= 0) begin
        e_dat[e_n] = s_dat[best];
        e_idx[e_n] = s_idx[best];
        last_idx   = int'(s_idx[best]);
        e_n++;
      end
    end
  endtask

  task automatic run_frame(input string req, input bit gaps);
    build_expect();
    for (int i = 0; i < s_n; i++) begin
      @(negedge clk);
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0;
        in_data  = 16'hFFFF;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = s_dat[i];
      in_idx   = s_idx[i];
      in_last  = (i == s_n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(out_valid == 1'b0, "R8", "out_valid one cycle after eof", int'(out_valid), 0);
    for (int k = 0; k < e_n; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R8", "out_valid during readout", int'(out_valid), 1);
      check(out_data == e_dat[k], req, "out_data (R2)", int'(out_data), int'(e_dat[k]));
      check(out_idx == e_idx[k], req, "out_idx (R3/R5)", int'(out_idx), int'(e_idx[k]));
      check(out_last == (k == e_n - 1), "R5", "out_last", int'(out_last), int'(k == e_n - 1));
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R6", "no extra entries", int'(out_valid), 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_last == 1'b0, "R1", "out_last in reset", int'(out_last), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic test_random();
    s_n = 64;
    for (int i = 0; i < s_n; i++) begin
      s_dat[i] = DW'($urandom_range(0, 65535));
      s_idx[i] = IW'(((i * 37) % 64) + 100);
    end
    run_frame("R2", 1'b0);
  endtask

  task automatic test_short();
    s_n = 10;
    for (int i = 0; i < s_n; i++) begin
      s_dat[i] = DW'(1000 - i * 50);
      s_idx[i] = IW'(500 - i * 7);
    end
    run_frame("R6", 1'b0);
    s_n = 1;
    s_dat[0] = 16'd42;
    s_idx[0] = 11'd9;
    run_frame("R6", 1'b0);
  endtask

  task automatic test_ties();
    s_n = 40;
    for (int i = 0; i < s_n; i++) begin
      s_dat[i] = 16'd500;
      s_idx[i] = IW'(39 - i);
    end
    run_frame("R4", 1'b0);
  endtask

  task automatic test_gaps();
    s_n = 50;
    for (int i = 0; i < s_n; i++) begin
      s_dat[i] = DW'((i * 7919) % 4096);
      s_idx[i] = IW'(i * 3);
    end
    run_frame("R10", 1'b1);
  endtask

  task automatic test_clear();
    s_n = 40;
    for (int i = 0; i < s_n; i++) begin
      s_dat[i] = DW'(60000 + i);
      s_idx[i] = IW'(i);
    end
    run_frame("R9", 1'b0);
    s_n = 5;
    for (int i = 0; i < s_n; i++) begin
      s_dat[i] = DW'(i + 1);
      s_idx[i] = IW'(200 + i);
    end
    run_frame("R9", 1'b0);
  endtask

  task automatic test_bypass();
    int n = 5;
    @(negedge clk);
    peak_en = 1'b0;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(out_valid == 1'b1, "R7", "pass valid", int'(out_valid), 1);
        check(out_data == DW'(9000 + i - 1), "R7", "pass data", int'(out_data), 9000 + i - 1);
        check(out_idx == IW'(i + 2), "R7", "pass idx", int'(out_idx), i + 2);
        check(out_last == (i == n), "R7", "pass last", int'(out_last), int'(i == n));
      end
      if (i < n) begin
        in_valid = 1'b1;
        in_data  = DW'(9000 + i);
        in_idx   = IW'(i + 3);
        in_last  = (i == n - 1);
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
        peak_en  = 1'b1;
      end
    end
    // Pass-through samples must not leak into the next peak frame
    s_n = 3;
    for (int i = 0; i < s_n; i++) begin
      s_dat[i] = DW'(10 + i);
      s_idx[i] = IW'(700 - i);
    end
    run_frame("R7", 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    test_reset();
    test_random();
    test_short();
    test_ties();
    test_gaps();
    test_clear();
    test_bypass();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule